// File: doc/BRIEF.md
# Burst Memory Target

This block is a single-clock memory target. It serves block write and block read transactions from one initiator through three separate handshake groups. The command group carries the transfer type, the start word address, the burst length and a byte selector for reads. The write group carries data words, per-byte write enables and an end-of-burst flag. The read group returns data words with an end-of-burst flag. Each group completes a transfer in any cycle where its valid and ready are both high, so one element per cycle can move in either direction.

The target owns a small word-addressed storage array. After it accepts a command, it walks that array one word per element, starting at the given address and wrapping modulo the depth. It holds off further commands until the last element of the current burst has moved. The length field is the element count minus one. A write burst ends at the earlier of two points: the initiator's end flag, or the count given in the command. When the two disagree, the block raises a one-cycle error pulse.

Top module: `burst_target`

## Requirements
- R1: While resetN is low and right after it rises, cmdReady is 1, wrReady is 0, rdValid is 0 and burstErr is 0, and every storage word reads back as zero.
- R2: A command is taken only while no burst is running. cmdReady is 0 from the cycle after a command is accepted until the cycle after the final element of that burst has completed.
- R3: cmdIsRead = 0 starts a write burst and cmdIsRead = 1 starts a read burst. cmdLenM1 holds the element count minus one, so a value of 2 moves three elements.
- R4: Write element i of a burst at start address A goes to word (A + i) mod depth. Only the bytes whose wrByteEn bit is set change, where bit k covers data bits 8k+7..8k.
- R5: rdValid goes high in the cycle after a read command is accepted. Elements come from consecutive wrapping addresses, one per cycle while rdReady stays high. rdLast is 1 exactly on the final element.
- R6: On read data, byte k (bits 8k+7..8k) is zero whenever bit k of the command's cmdByteSel was 0. All other bytes show the stored value.
- R7: While rdValid is 1 and rdReady is 0, rdData and rdLast stay unchanged. A write element is stored only in a cycle where wrValid and wrReady are both high.
- R8: A write burst ends at the earlier of wrLast or the command's element count. burstErr is 1 for exactly the one cycle after that final write if wrLast and the count disagreed, and 0 otherwise. Once a burst has ended, wrReady stays 0, so no further element is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| resetN | input | 1 | Asynchronous reset, active low |
| cmdIsRead | input | 1 | 1 = read burst, 0 = write burst |
| cmdAddr | input | ADDR_W | Start word address |
| cmdLenM1 | input | LEN_W | Element count minus one |
| cmdByteSel | input | DATA_W/8 | Per-byte enable applied to read data |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Command taken |
| wrData | input | DATA_W | Write element |
| wrByteEn | input | DATA_W/8 | Per-byte write enable |
| wrLast | input | 1 | Final write element marker |
| wrValid | input | 1 | Write element offered |
| wrReady | output | 1 | Write element taken |
| rdData | output | DATA_W | Read element |
| rdLast | output | 1 | Final read element marker |
| rdValid | output | 1 | Read element offered |
| rdReady | input | 1 | Read element taken |
| burstErr | output | 1 | One-cycle pulse on a write end-flag/count mismatch |

## Verification
The assertions assume reset is applied before any traffic. They also assume every input holds a known 0 or 1 value at each rising edge, because the stall, hold and end-of-burst properties compare sampled values across edges. The stimulus drives all inputs to defined levels from time zero and changes them only on falling edges. It offers write elements only inside write bursts, apart from one deliberate extra element used to probe R8, and it produces read stalls by lowering rdReady on alternate elements.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2
  } burstState_e;

  typedef struct packed {
    logic loadCmd;
    logic stepAddr;
    logic writeWord;
  } dpStrobes_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             resetN,
  input  logic             cmdIsRead,
  input  logic [LEN_W-1:0] cmdLenM1,
  input  logic             cmdValid,
  output logic             cmdReady,
  input  logic             wrLast,
  input  logic             wrValid,
  output logic             wrReady,
  output logic             rdValid,
  output logic             rdLast,
  input  logic             rdReady,
  output logic             burstErr,
  output dpStrobes_t       strobes
);
  burstState_e      stateQ;
  logic [LEN_W-1:0] remainQ;
  logic             errQ;
  logic             cmdFire, wrFire, rdFire, countDone;

  always_comb begin
    cmdReady  = (stateQ == ST_IDLE);
    wrReady   = (stateQ == ST_WRITE);
    rdValid   = (stateQ == ST_READ);
    countDone = (remainQ == '0);
    rdLast    = rdValid && countDone;
    cmdFire   = cmdValid && cmdReady;
    wrFire    = wrValid && wrReady;
    rdFire    = rdValid && rdReady;
    strobes.loadCmd   = cmdFire;
    strobes.stepAddr  = wrFire || rdFire;
    strobes.writeWord = wrFire;
    burstErr  = errQ;
  end

  always_ff @(posedge clk or negedge resetN) begin
    if (!resetN) begin
      stateQ  <= ST_IDLE;
      remainQ <= '0;
      errQ    <= 1'b0;
    end else begin
      errQ <= wrFire && (wrLast != countDone);
      case (stateQ)
        ST_IDLE: if (cmdFire) begin
          remainQ <= cmdLenM1;
          stateQ  <= cmdIsRead ? ST_READ : ST_WRITE;
        end
        ST_WRITE: if (wrFire) begin
          if (wrLast || countDone) stateQ <= ST_IDLE;
          else remainQ <= remainQ - 1'b1;
        end
        ST_READ: if (rdFire) begin
          if (countDone) stateQ <= ST_IDLE;
          else remainQ <= remainQ - 1'b1;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  // R2: no command can be taken while a burst channel is open
  a_r2_no_cmd_in_burst: assert property (@(posedge clk) disable iff (!resetN)
    cmdReady |-> !(wrReady || rdValid));

  // R7: a stalled read element keeps its end marker
  a_r7_rd_last_hold: assert property (@(posedge clk) disable iff (!resetN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdLast)));

  // R5: the read channel closes after the marked final element
  a_r5_rd_end: assert property (@(posedge clk) disable iff (!resetN)
    (rdValid && rdReady && rdLast) |=> !rdValid);

  // R8: the write channel closes after an end-flagged element
  a_r8_wr_end: assert property (@(posedge clk) disable iff (!resetN)
    (wrValid && wrReady && wrLast) |=> !wrReady);

  // R8: the mismatch flag lasts a single cycle
  a_r8_err_single: assert property (@(posedge clk) disable iff (!resetN)
    burstErr |=> !burstErr);
endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  resetN,
  input  dpStrobes_t            strobes,
  input  logic [ADDR_W-1:0]     cmdAddr,
  input  logic [DATA_W/8-1:0]   cmdByteSel,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [DATA_W/8-1:0]   wrByteEn,
  output logic [DATA_W-1:0]     rdWord
);
  localparam int NBYTES = DATA_W / 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] memQ [DEPTH];
  logic [ADDR_W-1:0] addrQ;
  logic [NBYTES-1:0] selQ;
  logic [DATA_W-1:0] curWord;

  always_ff @(posedge clk or negedge resetN) begin
    if (!resetN) begin
      addrQ <= '0;
      selQ  <= '0;
    end else if (strobes.loadCmd) begin
      addrQ <= cmdAddr;
      selQ  <= cmdByteSel;
    end else if (strobes.stepAddr) begin
      addrQ <= addrQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge resetN) begin
    if (!resetN) begin
      for (int w = 0; w < DEPTH; w++) memQ[w] <= '0;
    end else if (strobes.writeWord) begin
      for (int b = 0; b < NBYTES; b++)
        if (wrByteEn[b]) memQ[addrQ][b*8 +: 8] <= wrData[b*8 +: 8];
    end
  end

  assign curWord = memQ[addrQ];

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign rdWord[g*8 +: 8] = selQ[g] ? curWord[g*8 +: 8] : 8'h00;
  end

  // R4: each moved element advances the word pointer by one, wrapping
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!resetN)
    (strobes.stepAddr && !strobes.loadCmd) |=> (addrQ == $past(addrQ) + 1'b1));

  // R7: with no strobe active the presented word cannot change
  a_r7_rd_data_hold: assert property (@(posedge clk) disable iff (!resetN)
    !(strobes.stepAddr || strobes.loadCmd || strobes.writeWord) |=> $stable(rdWord));
endmodule

// File: rtl/burst_target.sv
module burst_target
  import burst_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 4
) (
  input  logic                clk,
  input  logic                resetN,
  input  logic                cmdIsRead,
  input  logic [ADDR_W-1:0]   cmdAddr,
  input  logic [LEN_W-1:0]    cmdLenM1,
  input  logic [DATA_W/8-1:0] cmdByteSel,
  input  logic                cmdValid,
  output logic                cmdReady,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [DATA_W/8-1:0] wrByteEn,
  input  logic                wrLast,
  input  logic                wrValid,
  output logic                wrReady,
  output logic [DATA_W-1:0]   rdData,
  output logic                rdLast,
  output logic                rdValid,
  input  logic                rdReady,
  output logic                burstErr
);
  dpStrobes_t strobes;

  burst_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .resetN(resetN), .cmdIsRead(cmdIsRead), .cmdLenM1(cmdLenM1),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .wrLast(wrLast), .wrValid(wrValid),
    .wrReady(wrReady), .rdValid(rdValid), .rdLast(rdLast), .rdReady(rdReady),
    .burstErr(burstErr), .strobes(strobes)
  );

  burst_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .resetN(resetN), .strobes(strobes), .cmdAddr(cmdAddr),
    .cmdByteSel(cmdByteSel), .wrData(wrData), .wrByteEn(wrByteEn), .rdWord(rdData)
  );
endmodule

// File: tb/sim_burst_target.sv
module sim_burst_target;
  localparam int AW = 4, DW = 32, LW = 4, NB = DW / 8, DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          resetN = 1'b0;
  logic          cmdIsRead = 1'b0;
  logic [AW-1:0] cmdAddr = '0;
  logic [LW-1:0] cmdLenM1 = '0;
  logic [NB-1:0] cmdByteSel = '0;
  logic          cmdValid = 1'b0;
  logic          cmdReady;
  logic [DW-1:0] wrData = '0;
  logic [NB-1:0] wrByteEn = '0;
  logic          wrLast = 1'b0;
  logic          wrValid = 1'b0;
  logic          wrReady;
  logic [DW-1:0] rdData;
  logic          rdLast;
  logic          rdValid;
  logic          rdReady = 1'b0;
  logic          burstErr;

  logic [DW-1:0] model [DEPTH];
  int errs = 0, checks = 0, cyc = 0;

  always #2 clk = ~clk;

  burst_target #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW)) u0 (
    .clk(clk), .resetN(resetN), .cmdIsRead(cmdIsRead), .cmdAddr(cmdAddr),
    .cmdLenM1(cmdLenM1), .cmdByteSel(cmdByteSel), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .wrData(wrData), .wrByteEn(wrByteEn), .wrLast(wrLast),
    .wrValid(wrValid), .wrReady(wrReady), .rdData(rdData), .rdLast(rdLast),
    .rdValid(rdValid), .rdReady(rdReady), .burstErr(burstErr)
  );

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pattern(input int s, input int l, input int i);
    return 32'h5A00_0000 ^ (32'(s) << 16) ^ (32'(l) << 8) ^ (32'(i) * 32'h3B) ^ (32'(i) << 24);
  endfunction

  function automatic logic [DW-1:0] masked(input logic [DW-1:0] w, input logic [NB-1:0] sel);
    logic [DW-1:0] r;
    for (int k = 0; k < NB; k++) r[k*8 +: 8] = sel[k] ? w[k*8 +: 8] : 8'h00;
    return r;
  endfunction

  task automatic sendCmd(input bit isRd, input int addr, input int lenm1, input logic [NB-1:0] sel);
    cmdIsRead = isRd; cmdAddr = AW'(addr); cmdLenM1 = LW'(lenm1); cmdByteSel = sel;
    cmdValid = 1'b1;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  // lastAt: index carrying wrLast (beyond lenm1 means never flagged)
  task automatic writeBurst(input int addr, input int lenm1, input int lastAt,
                            input logic [NB-1:0] be, input bit gaps);
    int fin;
    fin = (lastAt < lenm1) ? lastAt : lenm1;
    sendCmd(1'b0, addr, lenm1, 4'h0);
    for (int i = 0; i <= fin; i++) begin
      if (gaps && (i % 2 == 1)) begin
        wrValid = 1'b0;
        @(negedge clk);
      end
      check(cmdReady == 1'b0, "R2 busy during write", DW'(cmdReady), 0);
      wrData = pattern(addr, lenm1, i); wrByteEn = be; wrLast = (i == lastAt);
      wrValid = 1'b1;
      while (!wrReady) @(negedge clk);
      for (int k = 0; k < NB; k++)
        if (be[k]) model[(addr + i) % DEPTH][k*8 +: 8] = wrData[k*8 +: 8];
      @(negedge clk);
    end
    wrValid = 1'b0; wrLast = 1'b0;
    check(burstErr == (lastAt != lenm1), "R8 error pulse", DW'(burstErr), DW'(lastAt != lenm1));
    check(wrReady == 1'b0, "R8 write channel closed", DW'(wrReady), 0);
    check(cmdReady == 1'b1, "R2 idle after write", DW'(cmdReady), 1);
    @(negedge clk);
    check(burstErr == 1'b0, "R8 pulse one cycle", DW'(burstErr), 0);
  endtask

  task automatic readBurst(input int addr, input int lenm1, input logic [NB-1:0] sel,
                           input bit stall);
    logic [DW-1:0] exp;
    sendCmd(1'b1, addr, lenm1, sel);
    check(rdValid == 1'b1, "R5 read latency", DW'(rdValid), 1);
    for (int i = 0; i <= lenm1; i++) begin
      exp = masked(model[(addr + i) % DEPTH], sel);
      if (stall && (i % 2 == 0)) begin
        rdReady = 1'b0;
        @(negedge clk);
        check(rdValid && rdData == exp, "R7 stalled data held", rdData, exp);
        check(rdLast == (i == lenm1), "R7 stalled last held", DW'(rdLast), DW'(i == lenm1));
      end
      rdReady = 1'b1;
      check(cmdReady == 1'b0, "R2 busy during read", DW'(cmdReady), 0);
      check(rdValid && rdData == exp, "R4 R6 read data", rdData, exp);
      check(rdLast == (i == lenm1), "R3 R5 last marker", DW'(rdLast), DW'(i == lenm1));
      @(negedge clk);
    end
    rdReady = 1'b0;
    check(rdValid == 1'b0 && cmdReady == 1'b1, "R2 R5 read closed", DW'({rdValid, cmdReady}), 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errs++; checks++;
      $display("FAIL watchdog all requirements actual=%0d expected=<50000", cyc);
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < DEPTH; w++) model[w] = '0;
    repeat (3) @(negedge clk);
    check(cmdReady == 1'b1 && wrReady == 1'b0, "R1 reset ready levels", DW'({cmdReady, wrReady}), 2);
    check(rdValid == 1'b0 && burstErr == 1'b0, "R1 reset outputs low", DW'({rdValid, burstErr}), 0);
    resetN = 1'b1;
    @(negedge clk);
    check(cmdReady == 1'b1 && !wrReady && !rdValid && !burstErr, "R1 after release",
          DW'({cmdReady, wrReady, rdValid, burstErr}), 8);
    // R1: whole array reads as zero
    readBurst(0, DEPTH - 1, 4'hF, 1'b0);

    // R3 R4 R5 R6 R7: sweep lengths, start addresses (with wrap) and byte enables
    for (int len = 0; len < 4; len++) begin
      for (int si = 0; si < 3; si++) begin
        int st;
        logic [NB-1:0] be;
        st = (si == 0) ? 0 : (si == 1) ? 5 : 14;
        be = NB'((len * 5 + st) % 15 + 1);
        writeBurst(st, len, len, be, len[0]);
        readBurst(st, len, 4'hF, 1'b0);
        readBurst(st, len, NB'(4'b0101 ^ len), 1'b1);
      end
    end

    // R8: early end flag cuts a four-element burst after two elements
    writeBurst(8, 3, 1, 4'hF, 1'b0);
    readBurst(8, 3, 4'hF, 1'b0);

    // R8: count reached without end flag; an extra element is refused
    writeBurst(11, 1, 99, 4'hF, 1'b0);
    wrData = 32'hDEAD_BEEF; wrByteEn = 4'hF; wrValid = 1'b1;
    check(wrReady == 1'b0, "R8 extra element refused", DW'(wrReady), 0);
    @(negedge clk);
    wrValid = 1'b0;
    readBurst(11, 2, 4'hF, 1'b1);

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule